// File: doc/BRIEF.md
# Three-Stage Instruction Flow Sequencer

This block controls the flow of instructions through a small 32-bit core that has two instruction states: a wide state with 32-bit instructions and a compact state with 16-bit instructions. Each state owns a pair of pipeline slots. The fetch slot holds a valid flag, the address the word was read from, and the word. The decode slot holds a valid flag, the instruction address, and the decoded payload. When the step enable is high, the block does three things in the same step. It reads memory at the program counter. It moves the held fetch word into the decode slot. It issues the held decoded item to execute.

The execute side answers each issued item with an action. The action is either advance, which moves the PC on by the instruction size, or flush, which empties every slot and loads the PC from a target that execute supplies. The block reports the address of the next instruction that will execute. It works this out from which slots are occupied, so after a flush two refill steps pass before anything executes again.

The decoder is a stub that passes the word through; in the compact state it zero-extends the low half. Memory is a single-cycle read port that answers in the same cycle.

Top module: `fde_sequencer`

## Requirements
- R1: While reset is held and directly after it, both slot sets are empty, the PC (`mem_addr`) and `next_pc` equal the `RESET_VEC` parameter (default 0x0000_0100), and `exec_valid` is low.
- R2: `mem_addr` always equals the PC. `mem_half` is 1 in the compact state (`mode_compact`=1) and 0 in the wide state. A fetched word is stored with the PC it came from. In the compact state the word is `mem_rdata[15:0]` zero-extended to 32 bits; in the wide state it is all of `mem_rdata`.
- R3: On a step whose action is advance, the PC grows by 4 in the wide state and by 2 in the compact state, wrapping modulo 2^32.
- R4: During a step, `exec_valid` is high exactly when the active state's decode slot is full. While it is high, `exec_addr` and `exec_payload` show that entry's address and payload.
- R5: A step with `exec_valid` and `exec_flush` both high empties the fetch and decode slots of both states and loads the PC with `exec_target`.
- R6: When the active decode slot is empty, `exec_flush` and `exec_target` have no effect, and the step advances the PC.
- R7: `next_pc` equals the PC when the active state's slots are both empty. It equals the fetch slot's address when only that slot is full, and the decode slot's address when both are full.
- R8: The decode slot is loaded only from a full fetch slot. After reset or a flush, the first two steps leave `exec_valid` low, and the third step executes the word fetched by the first.
- R9: With `step_en` low, the PC, both slot sets and `next_pc` hold, and `exec_valid` is low.
- R10: Each state has its own slot set. A step acts only on the set selected by `mode_compact`, so switching state leaves the other set's contents in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | Perform one pipeline step at this edge |
| mode_compact | input | 1 | Instruction state: 0 wide (32-bit), 1 compact (16-bit) |
| mem_addr | output | 32 | Fetch address, equal to the PC |
| mem_half | output | 1 | Fetch is a 16-bit read |
| mem_rdata | input | 32 | Word returned for `mem_addr` in the same cycle |
| exec_valid | output | 1 | A decoded item is issued to execute this step |
| exec_addr | output | 32 | Address of the issued item |
| exec_payload | output | 32 | Decoded payload of the issued item |
| exec_flush | input | 1 | Execute action: 1 flush, 0 advance |
| exec_target | input | 32 | PC value that execute sets on a flush |
| next_pc | output | 32 | Address of the next instruction to execute |

## Verification
The assertions take for granted that memory answers in the same cycle, so the word on `mem_rdata` belongs to the current `mem_addr`. They also take for granted that `exec_flush` and `exec_target` are stable around the clock edge of a step. The bench changes every input only on the falling edge and derives `mem_rdata` combinationally from `mem_addr`. It drives flushes both with and without a full decode slot, so that the ignored case is exercised as well.

// File: rtl/fde_pkg.sv
package fde_pkg;
  typedef enum logic {
    ST_WIDE    = 1'b0,
    ST_COMPACT = 1'b1
  } isa_state_e;

  localparam int unsigned NUM_STATES = 2;
endpackage

// File: rtl/fde_rst_sync.sv
module fde_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/fde_decode_stub.sv
module fde_decode_stub #(
  parameter int unsigned IW      = 32,
  parameter int unsigned HW      = 16,
  parameter bit          COMPACT = 1'b0
) (
  input  logic [IW-1:0] word_i,
  output logic [IW-1:0] payload_o
);
  generate
    if (COMPACT) begin : g_half
      assign payload_o = {{(IW-HW){1'b0}}, word_i[HW-1:0]};
    end else begin : g_full
      assign payload_o = word_i;
    end
  endgenerate
endmodule

// File: rtl/fde_slots.sv
module fde_slots #(
  parameter int unsigned AW      = 32,
  parameter int unsigned IW      = 32,
  parameter int unsigned HW      = 16,
  parameter bit          COMPACT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          flush_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic [IW-1:0] fetch_word_i,
  output logic          f_valid_o,
  output logic [AW-1:0] f_addr_o,
  output logic          d_valid_o,
  output logic [AW-1:0] d_addr_o,
  output logic [IW-1:0] d_payload_o
);
  logic          f_valid_q, f_valid_n;
  logic [AW-1:0] f_addr_q,  f_addr_n;
  logic [IW-1:0] f_word_q,  f_word_n;
  logic          d_valid_q, d_valid_n;
  logic [AW-1:0] d_addr_q,  d_addr_n;
  logic [IW-1:0] d_pay_q,   d_pay_n;
  logic [IW-1:0] dec_payload;

  fde_decode_stub #(.IW(IW), .HW(HW), .COMPACT(COMPACT)) u_dec (
    .word_i    (f_word_q),
    .payload_o (dec_payload)
  );

  always_comb begin
    f_valid_n = f_valid_q;
    f_addr_n  = f_addr_q;
    f_word_n  = f_word_q;
    d_valid_n = d_valid_q;
    d_addr_n  = d_addr_q;
    d_pay_n   = d_pay_q;
    if (flush_i) begin
      f_valid_n = 1'b0;
      d_valid_n = 1'b0;
    end else if (adv_i) begin
      f_valid_n = 1'b1;
      f_addr_n  = fetch_addr_i;
      f_word_n  = fetch_word_i;
      if (f_valid_q) begin
        d_valid_n = 1'b1;
        d_addr_n  = f_addr_q;
        d_pay_n   = dec_payload;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_valid_q <= 1'b0;
      f_addr_q  <= '0;
      f_word_q  <= '0;
      d_valid_q <= 1'b0;
      d_addr_q  <= '0;
      d_pay_q   <= '0;
    end else if (flush_i || adv_i) begin
      f_valid_q <= f_valid_n;
      f_addr_q  <= f_addr_n;
      f_word_q  <= f_word_n;
      d_valid_q <= d_valid_n;
      d_addr_q  <= d_addr_n;
      d_pay_q   <= d_pay_n;
    end
  end

  assign f_valid_o   = f_valid_q;
  assign f_addr_o    = f_addr_q;
  assign d_valid_o   = d_valid_q;
  assign d_addr_o    = d_addr_q;
  assign d_payload_o = d_pay_q;

  // R2: a captured word carries the PC it was read from
  p_fetch_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !flush_i |=> f_valid_q && (f_addr_q == $past(fetch_addr_i)));

  // R5: a flush leaves this set empty
  p_flush_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !f_valid_q && !d_valid_q);

  // R8: an empty fetch slot does not disturb the decode slot
  p_decode_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !flush_i && !f_valid_q |=> (d_valid_q == $past(d_valid_q)) && $stable(d_addr_q));

  // R9/R10: without a step for this set nothing moves
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i && !flush_i |=> $stable(f_valid_q) && $stable(d_valid_q) && $stable(f_addr_q) && $stable(d_addr_q));

  // R7: a full decode slot is always backed by a full fetch slot
  p_slot_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid_q |-> f_valid_q);
endmodule

// File: rtl/fde_pc_unit.sv
module fde_pc_unit #(
  parameter int unsigned AW        = 32,
  parameter int unsigned IW        = 32,
  parameter int unsigned HW        = 16,
  parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          compact_i,
  input  logic          flush_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] pc_o
);
  localparam logic [AW-1:0] WIDE_INC    = AW'(IW / 8);
  localparam logic [AW-1:0] COMPACT_INC = AW'(HW / 8);

  logic [AW-1:0] pc_q, pc_n, inc;

  assign inc = compact_i ? COMPACT_INC : WIDE_INC;

  always_comb begin
    pc_n = pc_q;
    if (flush_i) pc_n = target_i;
    else if (step_i) pc_n = pc_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= AW'(RESET_VEC);
    else if (step_i || flush_i) pc_q <= pc_n;
  end

  assign pc_o = pc_q;

  // R3: advance adds the state's instruction size, wrapping
  p_pc_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !flush_i |=> pc_q == $past(pc_q) + (($past(compact_i)) ? AW'(2) : AW'(4)));

  // R5: flush loads the target
  p_pc_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> pc_q == $past(target_i));

  // R9: no step, no change
  p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i && !flush_i |=> $stable(pc_q));
endmodule

// File: rtl/fde_sequencer.sv
module fde_sequencer #(
  parameter int unsigned AW        = 32,
  parameter int unsigned IW        = 32,
  parameter int unsigned HW        = 16,
  parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          mode_compact,
  output logic [AW-1:0] mem_addr,
  output logic          mem_half,
  input  logic [IW-1:0] mem_rdata,
  output logic          exec_valid,
  output logic [AW-1:0] exec_addr,
  output logic [IW-1:0] exec_payload,
  input  logic          exec_flush,
  input  logic [AW-1:0] exec_target,
  output logic [AW-1:0] next_pc
);
  import fde_pkg::*;

  logic          rst_sync_n;
  logic [AW-1:0] pc;
  logic [IW-1:0] fetch_word;
  logic          flush_eff;
  isa_state_e    state;

  logic          f_valid   [NUM_STATES];
  logic [AW-1:0] f_addr    [NUM_STATES];
  logic          d_valid   [NUM_STATES];
  logic [AW-1:0] d_addr    [NUM_STATES];
  logic [IW-1:0] d_payload [NUM_STATES];

  logic          f_valid_act, d_valid_act;
  logic [AW-1:0] f_addr_act, d_addr_act;
  logic [IW-1:0] d_pay_act;

  fde_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign state      = mode_compact ? ST_COMPACT : ST_WIDE;
  assign fetch_word = (state == ST_COMPACT) ? {{(IW-HW){1'b0}}, mem_rdata[HW-1:0]} : mem_rdata;

  generate
    for (genvar s = 0; s < NUM_STATES; s++) begin : g_set
      logic adv;
      assign adv = step_en && (int'(state) == s);
      fde_slots #(.AW(AW), .IW(IW), .HW(HW), .COMPACT(s == int'(ST_COMPACT))) u_slots (
        .clk          (clk),
        .rst_n        (rst_sync_n),
        .adv_i        (adv),
        .flush_i      (flush_eff),
        .fetch_addr_i (pc),
        .fetch_word_i (fetch_word),
        .f_valid_o    (f_valid[s]),
        .f_addr_o     (f_addr[s]),
        .d_valid_o    (d_valid[s]),
        .d_addr_o     (d_addr[s]),
        .d_payload_o  (d_payload[s])
      );
    end
  endgenerate

  always_comb begin
    f_valid_act = f_valid[int'(state)];
    f_addr_act  = f_addr[int'(state)];
    d_valid_act = d_valid[int'(state)];
    d_addr_act  = d_addr[int'(state)];
    d_pay_act   = d_payload[int'(state)];
  end

  assign exec_valid   = step_en && d_valid_act;
  assign exec_addr    = d_addr_act;
  assign exec_payload = d_pay_act;
  assign flush_eff    = exec_valid && exec_flush;

  fde_pc_unit #(.AW(AW), .IW(IW), .HW(HW), .RESET_VEC(RESET_VEC)) u_pc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step_i    (step_en),
    .compact_i (mode_compact),
    .flush_i   (flush_eff),
    .target_i  (exec_target),
    .pc_o      (pc)
  );

  always_comb begin
    if (d_valid_act)      next_pc = d_addr_act;
    else if (f_valid_act) next_pc = f_addr_act;
    else                  next_pc = pc;
  end

  assign mem_addr = pc;
  assign mem_half = (state == ST_COMPACT);

  // R6: a flush request without a decoded item still advances
  p_ignore_flush_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_en && !d_valid_act && exec_flush |=> mem_addr == $past(mem_addr) + ($past(mode_compact) ? AW'(2) : AW'(4)));

  // R8: the step right after a flush issues nothing
  p_refill_gap_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush_eff |=> !exec_valid);

  // R5: after a flush both sets are empty, so next_pc is the target
  p_flush_nextpc_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush_eff |=> next_pc == $past(exec_target));
endmodule

// File: tb/sim_fde_sequencer.sv
module sim_fde_sequencer;
  localparam time CLK_P = 10ns;

  typedef struct packed {
    logic        fl;
    logic [31:0] tgt;
    logic        ev;
    logic [31:0] ea;
    logic [31:0] nxt;
    logic [31:0] pc;
  } vec_t;

  // wide state, starting from reset (PC 0x100)
  localparam vec_t VECS [7] = '{
    '{1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 32'h104},
    '{1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 32'h108},
    '{1'b0, 32'h0,   1'b1, 32'h100, 32'h104, 32'h10C},
    '{1'b1, 32'h200, 1'b1, 32'h104, 32'h200, 32'h200},
    '{1'b1, 32'h300, 1'b0, 32'h0,   32'h200, 32'h204},
    '{1'b0, 32'h0,   1'b0, 32'h0,   32'h200, 32'h208},
    '{1'b0, 32'h0,   1'b1, 32'h200, 32'h204, 32'h20C}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en;
  logic        mode_compact;
  logic [31:0] mem_addr;
  logic        mem_half;
  logic [31:0] mem_rdata;
  logic        exec_valid;
  logic [31:0] exec_addr;
  logic [31:0] exec_payload;
  logic        exec_flush;
  logic [31:0] exec_target;
  logic [31:0] next_pc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign mem_rdata = {~mem_addr[15:0], mem_addr[15:0]};

  fde_sequencer u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_en      (step_en),
    .mode_compact (mode_compact),
    .mem_addr     (mem_addr),
    .mem_half     (mem_half),
    .mem_rdata    (mem_rdata),
    .exec_valid   (exec_valid),
    .exec_addr    (exec_addr),
    .exec_payload (exec_payload),
    .exec_flush   (exec_flush),
    .exec_target  (exec_target),
    .next_pc      (next_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pay(input logic md, input logic [31:0] a);
    return md ? {16'h0, a[15:0]} : {~a[15:0], a[15:0]};
  endfunction

  task automatic step_chk(input logic md, input logic fl, input logic [31:0] tgt,
                          input logic ev, input logic [31:0] ea,
                          input logic [31:0] nxt, input logic [31:0] pc);
    @(negedge clk);
    step_en = 1'b1; mode_compact = md; exec_flush = fl; exec_target = tgt;
    #1;
    chk("R4 exec_valid", {31'h0, exec_valid}, {31'h0, ev});
    chk("R2 mem_half", {31'h0, mem_half}, {31'h0, md});
    if (ev) begin
      chk("R4 exec_addr", exec_addr, ea);
      chk("R2 exec_payload", exec_payload, exp_pay(md, ea));
    end
    @(posedge clk);
    #1;
    chk("R3 pc after step", mem_addr, pc);
    chk("R7 next_pc", next_pc, nxt);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; step_en = 1'b0; exec_flush = 1'b0; exec_target = '0; mode_compact = 1'b0;
    #1;
    chk("R1 pc in reset", mem_addr, 32'h100);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    step_en = 1'b1;
    #1;
    chk("R1 pc after reset", mem_addr, 32'h100);
    chk("R1 next_pc after reset", next_pc, 32'h100);
    chk("R1 exec_valid low", {31'h0, exec_valid}, 32'h0);
    step_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step_en = 1'b0; mode_compact = 1'b0; exec_flush = 1'b0; exec_target = '0;
    do_reset();

    // table walk: refill gap R8, flush R5, ignored flush R6, advance R3
    for (int i = 0; i < 7; i++) begin
      step_chk(1'b0, VECS[i].fl, VECS[i].tgt, VECS[i].ev, VECS[i].ea, VECS[i].nxt, VECS[i].pc);
    end

    // R9: idle cycles hold everything
    @(negedge clk);
    step_en = 1'b0; exec_flush = 1'b1; exec_target = 32'h500;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 pc held", mem_addr, 32'h20C);
    chk("R9 next_pc held", next_pc, 32'h204);
    chk("R9 exec_valid low", {31'h0, exec_valid}, 32'h0);

    // compact state with its own empty set, R10 R2 R3
    step_chk(1'b1, 1'b0, 32'h0, 1'b0, 32'h0,   32'h20C, 32'h20E);
    step_chk(1'b1, 1'b0, 32'h0, 1'b0, 32'h0,   32'h20C, 32'h210);
    step_chk(1'b1, 1'b0, 32'h0, 1'b1, 32'h20C, 32'h20E, 32'h212);

    // R10: back to wide, its set kept its entries
    @(negedge clk);
    step_en = 1'b0; mode_compact = 1'b0;
    #1;
    chk("R10 wide set kept", next_pc, 32'h204);

    // flush from wide clears the compact set too (R5)
    step_chk(1'b0, 1'b1, 32'h400, 1'b1, 32'h204, 32'h400, 32'h400);
    @(negedge clk);
    step_en = 1'b0; mode_compact = 1'b1; exec_flush = 1'b0;
    #1;
    chk("R5 compact set emptied", next_pc, 32'h400);

    // compact wrap of the PC (R3)
    step_chk(1'b1, 1'b0, 32'h0,         1'b0, 32'h0,   32'h400,       32'h402);
    step_chk(1'b1, 1'b0, 32'h0,         1'b0, 32'h0,   32'h400,       32'h404);
    step_chk(1'b1, 1'b1, 32'hFFFF_FFFE, 1'b1, 32'h400, 32'hFFFF_FFFE, 32'hFFFF_FFFE);
    step_chk(1'b1, 1'b0, 32'h0,         1'b0, 32'h0,   32'hFFFF_FFFE, 32'h0000_0000);

    // R1: reset in the middle of a run
    do_reset();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule